// File: doc/BRIEF.md
# Real-Time Clock with Coherent Time Snapshot

This block is a real-time-clock peripheral for a slow always-on timebase. It counts milliseconds and seconds from a slow-clock enable that arrives at nominally 32.768 kHz. A fractional accumulator turns the slow ticks into millisecond steps, so that one second is exactly one second's worth of slow ticks even when that tick count is not a whole multiple of the milliseconds per second. Software sees time only through bus-side copies of the counters. The block refreshes these copies once in every group of eight slow ticks. During the last slow-tick interval of each group a copy flag is raised. Software may read at any time. Any write made while the flag is high is dropped.

Time is read as a coherent pair. A read of the milliseconds register latches the bus-side seconds into a separate latched-seconds register, and software reads that register next. Three match comparators compare the counters with software-written values: two on seconds and one on milliseconds. They set bits in a write-one-to-clear flag register. A five-bit enable register selects which flags drive the single active-high level interrupt. Two further flag positions are reserved for countdown sources. Those positions exist in both registers, but no timer is built behind them.

The design is fully synchronous on the bus clock. The slow clock enters as a one-cycle enable `slow_tick`.

Top module: `slowclk_rtc`

## Requirements
- R1: After reset every readable register (time, latched seconds, match values, enable, flags) reads 0 and `irq` is low.
- R2: Each `slow_tick` adds MS_PER_SEC to a fraction accumulator. A millisecond step happens whenever the sum reaches TICKS_PER_SEC, and TICKS_PER_SEC is then subtracted. The millisecond count runs 0 to MS_PER_SEC-1 and carries into the seconds count, so one second takes exactly TICKS_PER_SEC slow ticks.
- R3: The copy flag (bit 0 of offset 0x004) is 1 during the eighth slow-tick interval of every group of eight, counting from reset. On the slow tick that ends this interval, the bus-side seconds (0x008) and milliseconds (0x010) take the updated live counts. They change at no other slow tick.
- R4: A write to seconds (0x008) while the copy flag is 0 loads the live seconds and the bus-side seconds with the written value. It also zeroes the milliseconds count and the fraction accumulator.
- R5: A write to any register while the copy flag is 1 has no effect.
- R6: A read of milliseconds (0x010) copies the bus-side seconds into latched seconds (0x00C). Latched seconds changes at no other time.
- R7: Flag bit 0 (or bit 1) is set when the seconds count steps up to a value equal to match 0 at 0x014 (or match 1 at 0x018). A match value of 0 disables that comparator.
- R8: Flag bit 2 is set when the milliseconds count steps to a value equal to the non-zero millisecond match value at 0x01C.
- R9: In the flag register (0x02C), writing 1 to a bit clears it and writing 0 leaves it unchanged. Flags are set whatever the enable bits hold. Bits 3 and 4 are never set. The enable register (0x028) stores bits 4:0, with the same bit positions as the flags.
- R10: `irq` is high exactly one cycle after any flag bit and its enable bit are both 1.
- R11: `rdata` holds the addressed register one cycle after `rd_en`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Active-high level interrupt |

## Verification
A drifting fraction accumulator shows up first in the millisecond value seen at a copy boundary. The clearest sign is the seconds carry landing one slow tick early or late, so the bench reads time on both sides of the exact second. A wrong copy phase shows in the copy flag and in the bus-side time within eight slow ticks. A stale or wrongly triggered latched-seconds register shows on the next latched read after time has moved on. Faults in the comparators or the flag logic show as a flag or `irq` that is wrong one cycle after the matching step, or after a clearing write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Register byte offsets
  localparam logic [11:0] OFS_COPYFLAG = 12'h004;
  localparam logic [11:0] OFS_SEC      = 12'h008;
  localparam logic [11:0] OFS_SECLATCH = 12'h00C;
  localparam logic [11:0] OFS_MSEC     = 12'h010;
  localparam logic [11:0] OFS_MATCH0   = 12'h014;
  localparam logic [11:0] OFS_MATCH1   = 12'h018;
  localparam logic [11:0] OFS_MSMATCH  = 12'h01C;
  localparam logic [11:0] OFS_IRQEN    = 12'h028;
  localparam logic [11:0] OFS_IRQFLG   = 12'h02C;

  // Interrupt source positions, shared by enable and flag registers
  localparam int SRC_MATCH0 = 0;
  localparam int SRC_MATCH1 = 1;
  localparam int SRC_MSMATCH = 2;
  localparam int SRC_SECDOWN = 3;
  localparam int SRC_MSDOWN  = 4;
  localparam int N_SRC       = 5;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int COPY_PERIOD   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_tick,
  input  logic restart,
  output logic ms_tick,
  output logic copy_stb,
  output logic busy
);
  localparam int ACC_W = $clog2(TICKS_PER_SEC + MS_PER_SEC) + 1;
  localparam int PH_W  = (COPY_PERIOD > 1) ? $clog2(COPY_PERIOD) : 1;
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(MS_PER_SEC);
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(TICKS_PER_SEC);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(COPY_PERIOD - 1);

  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [PH_W-1:0]  ph_q, ph_nxt;
  logic             busy_q;

  assign acc_sum = acc_q + STEP;
  assign ms_tick = slow_tick && !restart && (acc_sum >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc_q <= '0;
    end else if (slow_tick) begin
      acc_q <= (acc_sum >= LIMIT) ? acc_sum - LIMIT : acc_sum;
    end
  end

  assign ph_nxt = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      busy_q <= 1'b0;
    end else if (slow_tick) begin
      ph_q   <= ph_nxt;
      busy_q <= (ph_nxt == PH_LAST);
    end
  end

  assign busy     = busy_q;
  assign copy_stb = slow_tick && busy_q;

  assert_acc_bound_R2: assert property (@(posedge clk) disable iff (rst)
    acc_q < LIMIT);
  assert_busy_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q != $past(busy_q)) |-> $past(slow_tick));
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters #(
  parameter int SEC_W      = 32,
  parameter int MS_PER_SEC = 1000,
  localparam int MS_W      = $clog2(MS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             load,
  input  logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] sec_nxt,
  output logic [MS_W-1:0]  ms_nxt,
  output logic             sec_step,
  output logic             ms_step
);
  localparam logic [MS_W-1:0] MS_MAX = MS_W'(MS_PER_SEC - 1);

  logic [SEC_W-1:0] sec_q;
  logic [MS_W-1:0]  ms_q;
  logic             wrap;

  assign wrap     = (ms_q == MS_MAX);
  assign ms_step  = ms_tick && !load;
  assign sec_step = ms_step && wrap;

  always_comb begin
    sec_nxt = sec_q;
    ms_nxt  = ms_q;
    if (load) begin
      sec_nxt = load_val;
      ms_nxt  = '0;
    end else if (ms_tick) begin
      ms_nxt = wrap ? '0 : ms_q + 1'b1;
      if (wrap) sec_nxt = sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      ms_q  <= '0;
    end else begin
      sec_q <= sec_nxt;
      ms_q  <= ms_nxt;
    end
  end

  assert_ms_range_R2: assert property (@(posedge clk) disable iff (rst)
    ms_q <= MS_MAX);
  assert_sec_carry_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && (sec_q != $past(sec_q))) |-> ($past(ms_q) == MS_MAX && ms_q == '0));
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] flags_q, en_q;
  logic         irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (en_we) en_q <= en_wdata;
      irq_q   <= |(flags_q & en_q);
    end
  end

  assign flags = flags_q;
  assign en    = en_q;
  assign irq   = irq_q;

  assert_clear_only_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (($past(flags_q) & ~flags_q & ~$past(clr_vec)) == '0));
  assert_set_sticks_R9: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & ~flags_q) != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/slowclk_rtc.sv
module slowclk_rtc
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int COPY_PERIOD   = 8,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int SEC_W = DATA_W;
  localparam int MS_W  = $clog2(MS_PER_SEC);

  logic             busy, ms_tick, copy_stb, wr_ok, sec_load;
  logic [SEC_W-1:0] sec_nxt;
  logic [MS_W-1:0]  ms_nxt;
  logic             sec_step, ms_step;

  logic [SEC_W-1:0] sec_bus_q, latch_q, match0_q, match1_q;
  logic [MS_W-1:0]  ms_bus_q, msmatch_q;
  logic [N_SRC-1:0] set_vec, clr_vec, flags, en;
  logic [DATA_W-1:0] rd_d, rdata_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_ok    = wr_en && !busy;
  assign sec_load = wr_ok && hit(addr, OFS_SEC);

  rtc_timebase #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .MS_PER_SEC(MS_PER_SEC),
    .COPY_PERIOD(COPY_PERIOD)
  ) u_tb (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .restart(sec_load),
    .ms_tick(ms_tick), .copy_stb(copy_stb), .busy(busy)
  );

  rtc_counters #(
    .SEC_W(SEC_W),
    .MS_PER_SEC(MS_PER_SEC)
  ) u_cnt (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .load(sec_load),
    .load_val(wdata[SEC_W-1:0]), .sec_nxt(sec_nxt), .ms_nxt(ms_nxt),
    .sec_step(sec_step), .ms_step(ms_step)
  );

  // Bus-side copies, match registers and latched seconds
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_bus_q <= '0;
      ms_bus_q  <= '0;
      latch_q   <= '0;
      match0_q  <= '0;
      match1_q  <= '0;
      msmatch_q <= '0;
    end else begin
      if (copy_stb || sec_load) begin
        sec_bus_q <= sec_nxt;
        ms_bus_q  <= ms_nxt;
      end
      if (rd_en && hit(addr, OFS_MSEC)) latch_q <= sec_bus_q;
      if (wr_ok && hit(addr, OFS_MATCH0))  match0_q  <= wdata[SEC_W-1:0];
      if (wr_ok && hit(addr, OFS_MATCH1))  match1_q  <= wdata[SEC_W-1:0];
      if (wr_ok && hit(addr, OFS_MSMATCH)) msmatch_q <= wdata[MS_W-1:0];
    end
  end

  always_comb begin
    set_vec = '0;
    set_vec[SRC_MATCH0]  = sec_step && (match0_q != '0) && (sec_nxt == match0_q);
    set_vec[SRC_MATCH1]  = sec_step && (match1_q != '0) && (sec_nxt == match1_q);
    set_vec[SRC_MSMATCH] = ms_step && (msmatch_q != '0) && (ms_nxt == msmatch_q);
    set_vec[SRC_SECDOWN] = 1'b0;
    set_vec[SRC_MSDOWN]  = 1'b0;
    clr_vec = (wr_ok && hit(addr, OFS_IRQFLG)) ? wdata[N_SRC-1:0] : '0;
  end

  rtc_irq #(.N(N_SRC)) u_irq (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_we(wr_ok && hit(addr, OFS_IRQEN)), .en_wdata(wdata[N_SRC-1:0]),
    .flags(flags), .en(en), .irq(irq)
  );

  // Registered read port
  always_comb begin
    rd_d = '0;
    if (hit(addr, OFS_COPYFLAG))      rd_d[0] = busy;
    else if (hit(addr, OFS_SEC))      rd_d[SEC_W-1:0] = sec_bus_q;
    else if (hit(addr, OFS_SECLATCH)) rd_d[SEC_W-1:0] = latch_q;
    else if (hit(addr, OFS_MSEC))     rd_d[MS_W-1:0] = ms_bus_q;
    else if (hit(addr, OFS_MATCH0))   rd_d[SEC_W-1:0] = match0_q;
    else if (hit(addr, OFS_MATCH1))   rd_d[SEC_W-1:0] = match1_q;
    else if (hit(addr, OFS_MSMATCH))  rd_d[MS_W-1:0] = msmatch_q;
    else if (hit(addr, OFS_IRQEN))    rd_d[N_SRC-1:0] = en;
    else if (hit(addr, OFS_IRQFLG))   rd_d[N_SRC-1:0] = flags;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end
  assign rdata = rdata_q;

  assert_busy_write_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy && hit(addr, OFS_SEC)) |=> (sec_bus_q == $past(sec_bus_q)) || $past(copy_stb));
  assert_latch_only_on_ms_read_R6: assert property (@(posedge clk) disable iff (rst)
    (latch_q != $past(latch_q)) |-> $past(rd_en && hit(addr, OFS_MSEC)));
  assert_bus_copy_timing_R3: assert property (@(posedge clk) disable iff (rst)
    (ms_bus_q != $past(ms_bus_q)) |-> $past(copy_stb || sec_load));
endmodule

// File: tb/sim_slowclk_rtc.sv
module sim_slowclk_rtc;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 48;
  localparam int MPS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  int ph = 0;
  logic [31:0] v;

  localparam logic [7:0] A_FLAG = 8'h04, A_SEC = 8'h08, A_LATCH = 8'h0C,
    A_MS = 8'h10, A_M0 = 8'h14, A_M1 = 8'h18, A_MSM = 8'h1C,
    A_EN = 8'h28, A_IF = 8'h2C;

  always #(CLK_PERIOD/2) clk = ~clk;

  slowclk_rtc #(.TICKS_PER_SEC(TPS), .MS_PER_SEC(MPS)) u0 (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
      @(negedge clk);
      ph = (ph + 1) % 8;
    end
  endtask

  task automatic align();
    while (ph != 0) tick(1);
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] regs [9] = '{A_FLAG, A_SEC, A_LATCH, A_MS, A_M0, A_M1, A_MSM, A_EN, A_IF};
    for (int i = 0; i < 9; i++) begin
      rd(regs[i], v); chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", {31'd0, irq}, 0);
  endtask

  task automatic t_fraction();
    tick(47);
    rd(A_SEC, v); chk("R2 seconds one tick early", v, 0);
    rd(A_MS, v);  chk("R2 ms at copy 40", v, 8);
    rd(A_FLAG, v); chk("R3 copy flag high in 8th interval", v, 1);
    tick(1);
    rd(A_SEC, v); chk("R2 seconds after exact second", v, 1);
    rd(A_MS, v);  chk("R2 ms wrapped", v, 0);
    rd(A_FLAG, v); chk("R3 copy flag low", v, 0);
  endtask

  task automatic t_busy_write();
    align();
    wr(A_SEC, 32'h20);
    rd(A_SEC, v); chk("R4 seconds loaded", v, 32'h20);
    rd(A_MS, v);  chk("R4 ms cleared", v, 0);
    tick(7);
    rd(A_MS, v);  chk("R3 ms held between copies", v, 0);
    wr(A_SEC, 32'h55);
    tick(1);
    rd(A_SEC, v); chk("R5 busy seconds write dropped", v, 32'h20);
    rd(A_MS, v);  chk("R3 ms copied after fraction restart", v, 1);
  endtask

  task automatic t_sec_alarms();
    align();
    wr(A_SEC, 9); wr(A_M0, 10); wr(A_M1, 10); wr(A_EN, 1);
    tick(47);
    rd(A_IF, v); chk("R7 no flag before match", v, 0);
    tick(1); settle();
    rd(A_IF, v); chk("R7 both seconds matches flagged", v, 3);
    chk("R10 irq from enabled match0", {31'd0, irq}, 1);
    wr(A_IF, 1); settle();
    rd(A_IF, v); chk("R9 w1c clears bit0 only", v, 2);
    chk("R10 irq low, bit1 not enabled", {31'd0, irq}, 0);
    wr(A_IF, 0);
    rd(A_IF, v); chk("R9 write of 0 no effect", v, 2);
    wr(A_EN, 2); settle();
    chk("R10 enabling pending bit1 raises irq", {31'd0, irq}, 1);
    wr(A_IF, 2); settle();
    rd(A_IF, v); chk("R9 bit1 cleared", v, 0);
    chk("R10 irq drops after clear", {31'd0, irq}, 0);
    wr(A_M0, 0); wr(A_M1, 0); wr(A_EN, 0);
  endtask

  task automatic t_ms_alarm();
    align();
    wr(A_SEC, 0); wr(A_MSM, 3); wr(A_EN, 4);
    tick(14); settle();
    rd(A_IF, v); chk("R8 ms match not yet", v, 0);
    tick(1); settle();
    rd(A_IF, v); chk("R8 ms match flagged", v, 4);
    chk("R10 irq from ms match", {31'd0, irq}, 1);
    align();
    wr(A_MSM, 0); wr(A_IF, 4); wr(A_EN, 0);
    rd(A_IF, v); chk("R9 ms flag cleared", v, 0);
  endtask

  task automatic t_zero_disable();
    align();
    wr(A_SEC, 32'hFFFF_FFFF); wr(A_EN, 1);
    tick(48); settle();
    rd(A_SEC, v); chk("R2 seconds wrap to 0", v, 0);
    rd(A_IF, v);  chk("R7 zero match value disabled", v, 0);
    chk("R7 irq stays low", {31'd0, irq}, 0);
  endtask

  task automatic t_latch();
    align();
    wr(A_SEC, 200);
    rd(A_MS, v); chk("R6 ms read", v, 0);
    tick(48);
    rd(A_LATCH, v); chk("R6 latched seconds held", v, 200);
    rd(A_SEC, v);   chk("R6 live seconds moved", v, 201);
    rd(A_MS, v);
    rd(A_LATCH, v); chk("R6 relatch on ms read", v, 201);
  endtask

  task automatic t_enable_width();
    align();
    wr(A_EN, 32'h3F);
    rd(A_EN, v); chk("R9 enable holds 5 bits", v, 32'h1F);
    tick(7);
    wr(A_EN, 0);
    tick(1);
    rd(A_EN, v); chk("R5 busy enable write dropped", v, 32'h1F);
    rd(A_IF, v); chk("R9 countdown bits never set", v & 32'h18, 0);
    rd(8'h30, v); chk("R11 unmapped reads 0", v, 0);
    wr(A_EN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fraction();
    t_busy_write();
    t_sec_alarms();
    t_ms_alarm();
    t_zero_disable();
    t_latch();
    t_enable_width();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule